// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block sits beside a small 8-bit core and handles everything between "a request is pending" and "the first handler instruction is fetched". At each instruction boundary it looks at the software-trap strobe, a return command and up to fourteen maskable request lines. The maskable lines are gated by the I bit held in the core's condition-code register. It picks one winner by fixed priority and turns the winner into a 16-bit vector address.

On entry it writes the context to a stack page in memory as five bytes. It then fetches the two vector bytes, loads the program counter and sets the I bit. On a return command it reads the five bytes back in reverse order and restores the registers. All accesses go through a single-beat request/acknowledge memory port.

The block also raises a wake signal that lets the core leave a halted state. Only a subset of the sources can raise it. Reset puts the block into a boot sequence. That sequence fetches the reset vector and sets the I bit without touching the stack.

Top module: `irq_entry_seq`

## Requirements
- R1: Requests are evaluated only in a cycle where `insn_bnd` is high and `busy` is low. A maskable request is not taken while `cc_in[3]` (the I bit) is 1. When nothing is taken, `busy` stays 0 and no register load occurs.
- R2: Entry writes five bytes to addresses {0x01, sp} with a post-decrementing 8-bit stack pointer. The order is PC[7:0], PC[15:8], X, A, CC, so `sp_o` ends 5 below its start.
- R3: After stacking, the entry reads the vector high byte at the even address and the low byte at the odd address. It then loads PC with {high, low} and, in the same cycle, loads CC with `cc_in` with bit 3 set.
- R4: A return command at a boundary reads the five stack bytes in reverse order (CC, A, X, PC high, PC low) using a pre-incrementing pointer. It restores X, A, CC and PC, and `sp_o` returns to its value before the entry.
- R5: Priority is fixed. A software trap beats everything. A return command beats maskable requests. Among maskable sources the lowest index wins.
- R6: Winner code k (reset 0, trap 1, maskable source n as n+2) uses vector address 0xFFFE − 2k. `vec_addr` shows the address of the sequence in progress or the last one taken.
- R7: Sources 5, 7, 8, 9, 10, 12 and 13 are unused (mask 0x085F marks the used ones). A request on an unused line alone never starts a sequence.
- R8: `wake` is high exactly when request line 0 or 1 is high. The other lines never raise it.
- R9: The software trap is taken even when the I bit is 1.
- R10: Once a sequence has started, a new request, including a higher-priority one or a boundary strobe during `busy`, does not change it. The new request is only considered at the next boundary where the block is idle.
- R11: Reset aborts any sequence and sets `sp_o` to 0xFF without writing the stack. It then fetches the reset vector at 0xFFFE/0xFFFF, loads PC and sets bit 3 of CC.
- R12: `mem_req` together with its address, direction and write data stays stable until `mem_ack`. With an acknowledge in every cycle, an entry holds `busy` for 7 cycles and a return for 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 14 | Maskable request lines, index 0 highest |
| trap_req | input | 1 | Software trap instruction at this boundary |
| iret_req | input | 1 | Return-from-interrupt instruction at this boundary |
| insn_bnd | input | 1 | Instruction boundary strobe |
| pc_in | input | 16 | Core program counter |
| x_in | input | 8 | Core X register |
| a_in | input | 8 | Core accumulator |
| cc_in | input | 8 | Core condition codes, bit 3 is the I bit |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes in this cycle |
| pc_load | output | 1 | Load PC from pc_val |
| pc_val | output | 16 | New PC value |
| x_load | output | 1 | Load X from reg_val |
| a_load | output | 1 | Load A from reg_val |
| cc_load | output | 1 | Load CC from reg_val |
| reg_val | output | 8 | New 8-bit register value |
| sp_o | output | 8 | Stack pointer |
| vec_addr | output | 16 | Vector address of current or last sequence |
| busy | output | 1 | A sequence is in progress |
| wake | output | 1 | Wake request for a halted core |

## Verification
The bench builds the block with its default parameters: fourteen request lines, the 0x085F used mask, the wake mask on lines 0 and 1, stack page 0x01 and a top vector of 0xFFFE. With fourteen lines, every single-line request and every pair of used lines can be swept. This exercises every vector address, the unused-line rejection and the full priority order, each followed by a return that checks the stack round trip. The fixed five-byte context gives exact cycle counts. A mode that acknowledges every other cycle exercises the handshake holding its request.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_BOOT = 3'd0,
    ST_IDLE = 3'd1,
    ST_PUSH = 3'd2,
    ST_VECH = 3'd3,
    ST_VECL = 3'd4,
    ST_POP  = 3'd5
  } seq_st_e;

  localparam int unsigned CTX_BYTES = 5;
  localparam int unsigned CODE_RESET = 0;
  localparam int unsigned CODE_TRAP = 1;
  localparam int unsigned CODE_IRQ_BASE = 2;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned N = 14,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0] below;
  logic [N-1:0] gnt;

  assign below[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign below[i] = below[i-1] | req[i-1];
  end

  assign gnt   = req & ~below;
  assign valid = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
  parameter int unsigned CODE_W = 4,
  parameter logic [15:0] VEC_TOP = 16'hFFFE
) (
  input  logic [CODE_W-1:0] code,
  output logic [15:0]       vec
);
  always_comb begin
    vec = VEC_TOP - {15'(code), 1'b0};
  end
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_seq_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_INIT    = 8'hFF,
  parameter logic [15:0] VEC_RST    = 16'hFFFE,
  parameter int unsigned IBIT       = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_ent,
  input  logic [15:0] ent_vec,
  input  logic        start_ret,
  input  logic [15:0] pc_in,
  input  logic [7:0]  x_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  cc_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ack,
  output logic        pc_load,
  output logic [15:0] pc_val,
  output logic        x_load,
  output logic        a_load,
  output logic        cc_load,
  output logic [7:0]  reg_val,
  output logic [7:0]  sp_o,
  output logic [15:0] vec_o,
  output logic        busy
);
  localparam logic [2:0] LAST_BEAT = 3'(CTX_BYTES - 1);
  localparam logic [7:0] IMASK     = 8'(1 << IBIT);

  seq_st_e     st_q, st_d;
  logic [2:0]  beat_q, beat_d;
  logic [7:0]  sp_q, sp_d;
  logic [7:0]  pch_q, pch_d;
  logic [15:0] vec_q, vec_d;
  logic [7:0]  sp_inc;

  assign sp_inc = sp_q + 8'd1;

  always_comb begin
    st_d      = st_q;
    beat_d    = beat_q;
    sp_d      = sp_q;
    pch_d     = pch_q;
    vec_d     = vec_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    pc_load   = 1'b0;
    pc_val    = {pch_q, mem_rdata};
    x_load    = 1'b0;
    a_load    = 1'b0;
    cc_load   = 1'b0;
    reg_val   = mem_rdata;
    unique case (st_q)
      ST_BOOT: st_d = ST_VECH;
      ST_IDLE: begin
        if (start_ent) begin
          vec_d  = ent_vec;
          beat_d = '0;
          st_d   = ST_PUSH;
        end else if (start_ret) begin
          beat_d = '0;
          st_d   = ST_POP;
        end
      end
      ST_PUSH: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {STACK_PAGE, sp_q};
        unique case (beat_q)
          3'd0:    mem_wdata = pc_in[7:0];
          3'd1:    mem_wdata = pc_in[15:8];
          3'd2:    mem_wdata = x_in;
          3'd3:    mem_wdata = a_in;
          default: mem_wdata = cc_in;
        endcase
        if (mem_ack) begin
          sp_d = sp_q - 8'd1;
          if (beat_q == LAST_BEAT) st_d = ST_VECH;
          else beat_d = beat_q + 3'd1;
        end
      end
      ST_VECH: begin
        mem_req  = 1'b1;
        mem_addr = vec_q;
        if (mem_ack) begin
          pch_d = mem_rdata;
          st_d  = ST_VECL;
        end
      end
      ST_VECL: begin
        mem_req  = 1'b1;
        mem_addr = vec_q | 16'h0001;
        if (mem_ack) begin
          pc_load = 1'b1;
          cc_load = 1'b1;
          reg_val = cc_in | IMASK;
          st_d    = ST_IDLE;
        end
      end
      ST_POP: begin
        mem_req  = 1'b1;
        mem_addr = {STACK_PAGE, sp_inc};
        if (mem_ack) begin
          sp_d   = sp_inc;
          beat_d = beat_q + 3'd1;
          unique case (beat_q)
            3'd0:    cc_load = 1'b1;
            3'd1:    a_load  = 1'b1;
            3'd2:    x_load  = 1'b1;
            3'd3:    pch_d   = mem_rdata;
            default: begin
              pc_load = 1'b1;
              st_d    = ST_IDLE;
            end
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_BOOT;
      beat_q <= '0;
      sp_q   <= SP_INIT;
      pch_q  <= '0;
      vec_q  <= VEC_RST;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      sp_q   <= sp_d;
      pch_q  <= pch_d;
      vec_q  <= vec_d;
    end
  end

  assign sp_o  = sp_q;
  assign vec_o = vec_q;
  assign busy  = (st_q != ST_IDLE);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned NSRC       = 14,
  parameter logic [13:0] USED_MASK  = 14'h085F,
  parameter logic [13:0] WAKE_MASK  = 14'h0003,
  parameter logic [15:0] VEC_TOP    = 16'hFFFE,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_INIT    = 8'hFF,
  parameter int unsigned IBIT       = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            trap_req,
  input  logic            iret_req,
  input  logic            insn_bnd,
  input  logic [15:0]     pc_in,
  input  logic [7:0]      x_in,
  input  logic [7:0]      a_in,
  input  logic [7:0]      cc_in,
  output logic            mem_req,
  output logic            mem_we,
  output logic [15:0]     mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  input  logic            mem_ack,
  output logic            pc_load,
  output logic [15:0]     pc_val,
  output logic            x_load,
  output logic            a_load,
  output logic            cc_load,
  output logic [7:0]      reg_val,
  output logic [7:0]      sp_o,
  output logic [15:0]     vec_addr,
  output logic            busy,
  output logic            wake
);
  localparam int unsigned CODE_W = $clog2(NSRC + CODE_IRQ_BASE);
  localparam int unsigned IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic              rst_sync_n;
  logic [NSRC-1:0]   used_req;
  logic              arb_valid;
  logic [IDX_W-1:0]  arb_idx;
  logic              at_bnd;
  logic              take_trap, take_ret, take_irq;
  logic [CODE_W-1:0] win_code;
  logic [15:0]       win_vec;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign used_req = irq_req & USED_MASK[NSRC-1:0];

  irq_prio_arb #(.N(NSRC)) u_arb (
    .req   (used_req),
    .valid (arb_valid),
    .idx   (arb_idx)
  );

  always_comb begin
    at_bnd    = insn_bnd & ~busy;
    take_trap = at_bnd & trap_req;
    take_ret  = at_bnd & ~trap_req & iret_req;
    take_irq  = at_bnd & ~trap_req & ~iret_req & ~cc_in[IBIT] & arb_valid;
    if (take_trap) win_code = CODE_W'(CODE_TRAP);
    else           win_code = CODE_W'(arb_idx) + CODE_W'(CODE_IRQ_BASE);
  end

  irq_vec_map #(.CODE_W(CODE_W), .VEC_TOP(VEC_TOP)) u_vec (
    .code (win_code),
    .vec  (win_vec)
  );

  irq_ctx_seq #(
    .STACK_PAGE (STACK_PAGE),
    .SP_INIT    (SP_INIT),
    .VEC_RST    (VEC_TOP),
    .IBIT       (IBIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_ent (take_trap | take_irq),
    .ent_vec   (win_vec),
    .start_ret (take_ret),
    .pc_in     (pc_in),
    .x_in      (x_in),
    .a_in      (a_in),
    .cc_in     (cc_in),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .pc_load   (pc_load),
    .pc_val    (pc_val),
    .x_load    (x_load),
    .a_load    (a_load),
    .cc_load   (cc_load),
    .reg_val   (reg_val),
    .sp_o      (sp_o),
    .vec_o     (vec_addr),
    .busy      (busy)
  );

  assign wake = |(irq_req & WAKE_MASK[NSRC-1:0] & USED_MASK[NSRC-1:0]);
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int unsigned NSRC       = 14,
  parameter logic [13:0] WAKE_MASK  = 14'h0003,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter int unsigned IBIT       = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_req,
  input logic            insn_bnd,
  input logic            mem_req,
  input logic            mem_we,
  input logic [15:0]     mem_addr,
  input logic [7:0]      mem_wdata,
  input logic            mem_ack,
  input logic            pc_load,
  input logic            x_load,
  input logic            a_load,
  input logic            cc_load,
  input logic [7:0]      reg_val,
  input logic [7:0]      sp_o,
  input logic            busy,
  input logic            wake
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_no_idle_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !insn_bnd) |=> !busy);

  assert_write_in_stack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr[15:8] == STACK_PAGE));

  assert_sp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_o) |-> ((sp_o == $past(sp_o) + 8'd1) || (sp_o == $past(sp_o) - 8'd1)));

  assert_load_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load || x_load || a_load || cc_load) |-> (mem_req && mem_ack && !mem_we));

  assert_entry_sets_i_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && cc_load) |-> reg_val[IBIT]);

  assert_single_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_load, x_load, a_load}));

  assert_wake_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (|(irq_req & WAKE_MASK[NSRC-1:0])));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .NSRC       (NSRC),
  .WAKE_MASK  (WAKE_MASK),
  .STACK_PAGE (STACK_PAGE),
  .IBIT       (IBIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .insn_bnd  (insn_bnd),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .pc_load   (pc_load),
  .x_load    (x_load),
  .a_load    (a_load),
  .cc_load   (cc_load),
  .reg_val   (reg_val),
  .sp_o      (sp_o),
  .busy      (busy),
  .wake      (wake)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [13:0] USED = 14'h085F;

  logic        clk;
  logic        rst_n;
  logic [13:0] irq_req;
  logic        trap_req, iret_req, insn_bnd;
  logic [15:0] pc_r;
  logic [7:0]  x_r, a_r, cc_r;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        pc_load, x_load, a_load, cc_load;
  logic [15:0] pc_val, vec_addr;
  logic [7:0]  reg_val, sp_o;
  logic        busy, wake;

  logic        preset;
  logic [15:0] set_pc;
  logic [7:0]  set_x, set_a, set_cc;
  logic        stall;
  logic [31:0] cyc;
  logic [7:0]  stk [256];
  int          n_tests, n_fail;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .trap_req(trap_req),
    .iret_req(iret_req), .insn_bnd(insn_bnd), .pc_in(pc_r), .x_in(x_r),
    .a_in(a_r), .cc_in(cc_r), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .pc_load(pc_load), .pc_val(pc_val), .x_load(x_load),
    .a_load(a_load), .cc_load(cc_load), .reg_val(reg_val), .sp_o(sp_o),
    .vec_addr(vec_addr), .busy(busy), .wake(wake)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 32'd1;

  // memory model: stack page RAM, computed vector bytes
  assign mem_ack = mem_req & (~stall | cyc[0]);
  always_comb begin
    if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
    else if (!mem_addr[0])       mem_rdata = {1'b1, mem_addr[7:1]};
    else                         mem_rdata = mem_addr[7:0];
  end
  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ack && mem_addr[15:8] == 8'h01)
      stk[mem_addr[7:0]] <= mem_wdata;
  end

  // core register model
  always @(posedge clk) begin
    if (preset) begin
      pc_r <= set_pc; x_r <= set_x; a_r <= set_a; cc_r <= set_cc;
    end else begin
      if (pc_load) pc_r <= pc_val;
      if (x_load)  x_r  <= reg_val;
      if (a_load)  a_r  <= reg_val;
      if (cc_load) cc_r <= reg_val;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(input int code);
    return 16'hFFFE - 16'(2 * code);
  endfunction

  function automatic logic [15:0] pc_of(input int code);
    logic [15:0] va;
    va = vec_of(code);
    return {1'b1, va[7:1], va[7:0] | 8'h01};
  endfunction

  task automatic preset_core(input logic [15:0] p, input logic [7:0] x, input logic [7:0] a, input logic [7:0] c);
    @(negedge clk);
    set_pc = p; set_x = x; set_a = a; set_cc = c; preset = 1'b1;
    @(negedge clk);
    preset = 1'b0;
  endtask

  task automatic boundary(input logic [13:0] req, input logic trp, input logic ret);
    @(negedge clk);
    irq_req = req; trap_req = trp; iret_req = ret; insn_bnd = 1'b1;
    @(negedge clk);
    insn_bnd = 1'b0; trap_req = 1'b0; iret_req = 1'b0;
  endtask

  task automatic wait_idle(output int k);
    k = 0;
    while (busy && k < 400) begin
      @(negedge clk);
      k++;
    end
  endtask

  // one entry for the request pattern, then a return; code -1 = not taken
  task automatic entry_ret(input logic [13:0] req, input logic trp, input int code, input int seed, input string tag);
    logic [15:0] p;
    logic [7:0]  x, a, c;
    int k;
    p = 16'hA000 + 16'(seed * 16'h0111);
    x = 8'h10 + 8'(seed);
    a = 8'hC0 ^ 8'(seed);
    c = 8'h21 | (8'(seed) & 8'hF0) & 8'hF7;
    preset_core(p, x, a, c);
    boundary(req, trp, 1'b0);
    irq_req = '0;
    if (code < 0) begin
      chk({tag, " R1/R7 not taken busy"}, 32'(busy), 32'd0);
      @(negedge clk);
      chk({tag, " R7 pc untouched"}, 32'(pc_r), 32'(p));
      return;
    end
    wait_idle(k);
    if (!stall) chk({tag, " R12 entry cycles"}, k, 7);
    chk({tag, " R3 pc from vector"}, 32'(pc_r), 32'(pc_of(code)));
    chk({tag, " R3 I bit set"}, 32'(cc_r), 32'(c | 8'h08));
    chk({tag, " R6 vec_addr"}, 32'(vec_addr), 32'(vec_of(code)));
    chk({tag, " R2 sp after push"}, 32'(sp_o), 32'h0FA);
    chk({tag, " R2 stack bytes"}, {stk[8'hFF], stk[8'hFE], stk[8'hFD], stk[8'hFC]}, {p[7:0], p[15:8], x, a});
    chk({tag, " R2 stacked cc"}, 32'(stk[8'hFB]), 32'(c));
    boundary('0, 1'b0, 1'b1);
    wait_idle(k);
    if (!stall) chk({tag, " R12 return cycles"}, k, 5);
    chk({tag, " R4 restored pc"}, 32'(pc_r), 32'(p));
    chk({tag, " R4 restored x/a/cc"}, {8'h0, x_r, a_r, cc_r}, {8'h0, x, a, c});
    chk({tag, " R4 sp back"}, 32'(sp_o), 32'h0FF);
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    wait (cyc > 32'd150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int k;
    cyc = '0;
    rst_n = 1'b0; stall = 1'b0; preset = 1'b0;
    irq_req = '0; trap_req = 1'b0; iret_req = 1'b0; insn_bnd = 1'b0;
    set_pc = '0; set_x = '0; set_a = '0; set_cc = '0;
    preset_core(16'h5555, 8'h11, 8'h22, 8'h21);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_idle(k);
    chk("R11 reset pc vector", 32'(pc_r), 32'(pc_of(0)));
    chk("R11 reset I bit", 32'(cc_r), 32'h29);
    chk("R11 reset sp", 32'(sp_o), 32'h0FF);
    chk("R11 reset vec_addr", 32'(vec_addr), 32'hFFFE);

    // R8 wake sweep
    for (int n = 0; n < 14; n++) begin
      @(negedge clk);
      irq_req = 14'(1) << n;
      #1;
      chk($sformatf("R8 wake src %0d", n), 32'(wake), 32'(n < 2));
    end
    irq_req = '0;

    // R6/R7 single-source sweep
    for (int n = 0; n < 14; n++)
      entry_ret(14'(1) << n, 1'b0, USED[n] ? n + 2 : -1, n, $sformatf("single %0d", n));

    // R5 pair sweep over used sources
    for (int i = 0; i < 14; i++)
      for (int j = i + 1; j < 14; j++)
        if (USED[i] && USED[j])
          entry_ret((14'(1) << i) | (14'(1) << j), 1'b0, i + 2, i + j, $sformatf("R5 pair %0d/%0d", i, j));

    // R5 trap beats maskable; R6 trap vector
    entry_ret(14'h0001, 1'b1, 1, 3, "R5 trap over irq0");

    // R1 masked by I bit; R9 trap ignores I bit
    preset_core(16'h4321, 8'h01, 8'h02, 8'h08);
    boundary(14'h085F, 1'b0, 1'b0);
    irq_req = '0;
    chk("R1 I bit masks requests", 32'(busy), 32'd0);
    boundary('0, 1'b1, 1'b0);
    wait_idle(k);
    chk("R9 trap with I set pc", 32'(pc_r), 32'(pc_of(1)));
    boundary('0, 1'b0, 1'b1);
    wait_idle(k);
    chk("R9 return after trap pc", 32'(pc_r), 32'h4321);

    // R1 no boundary, no start
    preset_core(16'h2000, 8'h01, 8'h02, 8'h00);
    @(negedge clk); irq_req = 14'h0001;
    repeat (3) @(negedge clk);
    chk("R1 no boundary no entry", 32'(busy), 32'd0);
    irq_req = '0;

    // R10 late higher-priority request waits
    boundary(14'h0040, 1'b0, 1'b0);
    irq_req = 14'h0001;
    @(negedge clk); insn_bnd = 1'b1;
    @(negedge clk); insn_bnd = 1'b0;
    wait_idle(k);
    chk("R10 first winner kept", 32'(pc_r), 32'(pc_of(8)));
    boundary(14'h0001, 1'b0, 1'b0);
    chk("R10 R1 late request masked in handler", 32'(busy), 32'd0);
    boundary(14'h0001, 1'b0, 1'b1);
    wait_idle(k);
    chk("R5 return beats irq pc", 32'(pc_r), 32'h2000);
    boundary(14'h0001, 1'b0, 1'b0);
    irq_req = '0;
    wait_idle(k);
    chk("R10 pending taken at next boundary", 32'(pc_r), 32'(pc_of(2)));
    boundary('0, 1'b0, 1'b1);
    wait_idle(k);

    // R12 with acknowledge stalls
    stall = 1'b1;
    entry_ret(14'h0800, 1'b0, 13, 9, "R12 stalled src11");
    entry_ret(14'h0010, 1'b1, 1, 6, "R12 stalled trap");
    stall = 1'b0;

    // R11 reset during stacking
    preset_core(16'h7777, 8'h01, 8'h02, 8'h40);
    boundary(14'h0008, 1'b0, 1'b0);
    irq_req = '0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_idle(k);
    chk("R11 abort pc reset vector", 32'(pc_r), 32'(pc_of(0)));
    chk("R11 abort sp reinit", 32'(sp_o), 32'h0FF);
    chk("R11 abort I set", 32'(cc_r), 32'h48);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule